// File: doc/BRIEF.md
# Predicated Control-Transfer Condition Unit

This block decides whether a conditional control transfer is taken and where it goes. It keeps a file of one-bit predicates, written by compare results, and a small bank of numbered transfer-target slots. Software loads a slot ahead of time with a 32-bit prepare word and the address of the current instruction. A later transfer request names a slot and carries a 9-bit condition code. The unit evaluates the code against one selected predicate and the loop-end status. It then reports, one cycle later, a taken flag, the kind of transfer and the prepared target or system-call number.

A prepare word splits into three fields. Bits 31:30 name the slot (1, 2 or 3; 0 names none). Bits 29:28 give the kind: 0 relative jump, 1 prefetch-program load, 2 system call, 3 return. Bits 27:0 carry an offset or a call number. Relative and prefetch targets are counted in 8-byte units from the instruction address. Ill-formed prepares are flagged at once and remembered in the slot, so a later request from that slot is reported illegal and not taken.

Top module: `xfer_cond_unit`

## Requirements
- R1: After reset, res_valid, res_taken and prep_err are low, every predicate reads 0, and every slot counts as never prepared.
- R2: A predicate write (pw_valid, pw_index, pw_value) updates that entry at the clock edge. A request in the same cycle evaluates with the value from before the write.
- R3: The condition code holds the predicate index in bits 4:0 and the type in bits 8:5. With predicate p and loop-end l, the types give taken as follows: 0 never, 1 always, 2 p, 3 not p, 4 l, 5 not l, 6 p or l, 7 (not p) and (not l).
- R4: Type 14 is taken on (not p) or l, and type 15 is taken on p and (not l).
- R5: Types 8 to 13 are never taken and set res_illegal_cond in the result.
- R6: Each request gives exactly one result, one cycle later: res_valid high, with res_kind equal to the kind stored in the named slot (0 rel, 1 prefetch, 2 syscall, 3 return).
- R7: For kinds 0 and 1 the target is the instruction address plus bits 27:0 (zero-extended) times 8, modulo 2^ADDR_W. For example, 0x42 at 0x1000 gives 0x1210.
- R8: For kind 2 the target is bits 27:0 zero-extended and unshifted. For kind 3 the target is 0.
- R9: res_illegal_slot is set, and res_taken is low, when the request names slot 0 or an unprepared slot. The same holds for a slot whose last prepare was kind 1 to a slot other than 2, or kind 3 with a nonzero bits 27:0.
- R10: prep_err pulses one cycle after a prepare that names slot 0 or has an illegal kind/offset combination. A prepare naming slot 0 leaves all slots unchanged.
- R11: A request and a prepare to the same slot in the same cycle give the slot's old contents. The new contents apply from the next request on.
- R12: loop_end is sampled in the same cycle as the request it qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pw_valid | input | 1 | Predicate write strobe |
| pw_index | input | 5 | Predicate entry to write |
| pw_value | input | 1 | Value written |
| loop_end | input | 1 | Loop-end status for the current request |
| prep_valid | input | 1 | Prepare strobe |
| prep_word | input | 32 | Prepare word: slot, kind, offset/number |
| prep_pc | input | ADDR_W | Address of the preparing instruction |
| req_valid | input | 1 | Transfer request strobe |
| req_cond | input | 9 | Condition code: type 8:5, predicate index 4:0 |
| req_slot | input | 2 | Slot used by the request |
| res_valid | output | 1 | Result strobe, one cycle after a request |
| res_taken | output | 1 | Transfer is taken |
| res_kind | output | 2 | Kind of the prepared transfer |
| res_target | output | ADDR_W | Prepared target or system-call number |
| res_illegal_cond | output | 1 | Condition type is reserved or undefined |
| res_illegal_slot | output | 1 | Slot is zero, unprepared or ill-formed |
| prep_err | output | 1 | Previous prepare was ill-formed |

## Verification
The bench sweeps all 32 predicate indices against all 16 condition types at both loop-end levels. A polarity mistake or a swapped AND/OR form in one type therefore shows up as a wrong taken flag at particular predicate values. Address arithmetic is checked with the 0x1000 example and with a maximum offset that wraps the address. A design that shifted the system-call number, or forgot to clear a return target, shows a wrong res_target. Same-cycle collisions are checked for both predicates and slots: a design that forwards the new value would report the written value instead of the old one. Slot-0, wrong-slot prefetch and nonzero-offset return prepares are checked for both prep_err and a later illegal, untaken request, and slot 0 is checked to leave the other slots intact.

// File: rtl/xcu_pkg.sv
package xcu_pkg;

   localparam int CODE_W   = 9;
   localparam int PIDX_W   = 5;
   localparam int CTYPE_W  = 4;
   localparam int WORD_W   = 32;
   localparam int FIELD_W  = 28;
   localparam int SCALE_SH = 3;
   localparam int SLOT_W   = 2;

   typedef enum logic [1:0] {
      XK_REL = 2'd0,
      XK_PFL = 2'd1,
      XK_SYS = 2'd2,
      XK_RET = 2'd3
   } xfer_kind_e;

   typedef enum logic [CTYPE_W-1:0] {
      CT_NEVER      = 4'd0,
      CT_ALWAYS     = 4'd1,
      CT_P          = 4'd2,
      CT_NP         = 4'd3,
      CT_LE         = 4'd4,
      CT_NLE        = 4'd5,
      CT_P_OR_LE    = 4'd6,
      CT_NP_AND_NLE = 4'd7,
      CT_NP_OR_LE   = 4'd14,
      CT_P_AND_NLE  = 4'd15
   } cond_type_e;

   typedef struct packed {
      logic       valid;
      logic       bad;
      xfer_kind_e kind;
   } slot_tag_t;

endpackage

// File: rtl/xcu_pred_file.sv
module xcu_pred_file
   import xcu_pkg::*;
#(
   parameter int NPRED = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PIDX_W-1:0] wr_idx,
   input  logic              wr_val,
   input  logic [PIDX_W-1:0] rd_idx,
   output logic              rd_val
);

   localparam int SPAN = 1 << PIDX_W;

   if (NPRED < 1 || NPRED > SPAN) begin : g_bad_npred
      $error("xcu_pred_file: NPRED must be within 1..%0d", SPAN);
   end

   logic [NPRED-1:0] bits_q;
   logic [SPAN-1:0]  padded;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bits_q <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < NPRED; i++) begin
            if (wr_idx == PIDX_W'(i)) bits_q[i] <= wr_val;
         end
      end
   end

   if (NPRED == SPAN) begin : g_full
      assign padded = bits_q;
   end else begin : g_part
      assign padded = {{(SPAN-NPRED){1'b0}}, bits_q};
   end

   // old value is read: the register updates only at the edge
   assign rd_val = padded[rd_idx];

   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (32'(wr_idx) < NPRED) |=> padded[$past(wr_idx)] == $past(wr_val));

endmodule

// File: rtl/xcu_cond_eval.sv
module xcu_cond_eval
   import xcu_pkg::*;
(
   input  logic [CTYPE_W-1:0] ctype,
   input  logic               pred,
   input  logic               loop_end,
   output logic               hit,
   output logic               bad_code
);

   always_comb begin
      hit      = 1'b0;
      bad_code = 1'b0;
      case (cond_type_e'(ctype))
         CT_NEVER:      hit = 1'b0;
         CT_ALWAYS:     hit = 1'b1;
         CT_P:          hit = pred;
         CT_NP:         hit = !pred;
         CT_LE:         hit = loop_end;
         CT_NLE:        hit = !loop_end;
         CT_P_OR_LE:    hit = pred || loop_end;
         CT_NP_AND_NLE: hit = !pred && !loop_end;
         CT_NP_OR_LE:   hit = !pred || loop_end;
         CT_P_AND_NLE:  hit = pred && !loop_end;
         default:       bad_code = 1'b1;
      endcase
   end

endmodule

// File: rtl/xcu_prep_bank.sv
module xcu_prep_bank
   import xcu_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int NSLOT  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [ADDR_W-1:0] wr_pc,
   output logic              wr_err,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic              rd_ok,
   output logic [1:0]        rd_kind,
   output logic [ADDR_W-1:0] rd_target
);

   localparam int SH_PAD = ADDR_W - FIELD_W - SCALE_SH;
   localparam int ZX_PAD = ADDR_W - FIELD_W;
   localparam int PFL_SLOT = 2;

   if (ADDR_W < FIELD_W + SCALE_SH + 1) begin : g_bad_addr
      $error("xcu_prep_bank: ADDR_W too narrow for a scaled offset");
   end
   if (NSLOT < 1 || NSLOT > (1 << SLOT_W) - 1) begin : g_bad_nslot
      $error("xcu_prep_bank: NSLOT must be within 1..3");
   end

   logic [SLOT_W-1:0]  w_slot;
   xfer_kind_e         w_kind;
   logic [FIELD_W-1:0] w_field;
   logic               w_slot_in;
   logic               w_bad;
   logic [ADDR_W-1:0]  w_tgt;

   assign w_slot  = wr_word[WORD_W-1 -: SLOT_W];
   assign w_kind  = xfer_kind_e'(wr_word[FIELD_W+1:FIELD_W]);
   assign w_field = wr_word[FIELD_W-1:0];

   assign w_slot_in = (w_slot != '0) && (32'(w_slot) <= NSLOT);

   always_comb begin
      w_bad = 1'b0;
      if (w_kind == XK_PFL && w_slot != SLOT_W'(PFL_SLOT)) w_bad = 1'b1;
      if (w_kind == XK_RET && w_field != '0)               w_bad = 1'b1;
   end

   always_comb begin
      case (w_kind)
         XK_REL, XK_PFL: w_tgt = wr_pc + {{SH_PAD{1'b0}}, w_field, {SCALE_SH{1'b0}}};
         XK_SYS:         w_tgt = {{ZX_PAD{1'b0}}, w_field};
         default:        w_tgt = '0;
      endcase
   end

   assign wr_err = !w_slot_in || w_bad;

   slot_tag_t         tag_a [NSLOT];
   logic [ADDR_W-1:0] tgt_a [NSLOT];
   logic [NSLOT-1:0]  valid_vec;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      slot_tag_t         tag_q;
      logic [ADDR_W-1:0] tgt_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tag_q <= '{valid: 1'b0, bad: 1'b0, kind: XK_REL};
            tgt_q <= '0;
         end else if (wr_en && w_slot == SLOT_W'(s + 1)) begin
            tag_q <= '{valid: 1'b1, bad: w_bad, kind: w_kind};
            tgt_q <= w_tgt;
         end
      end

      assign tag_a[s]     = tag_q;
      assign tgt_a[s]     = tgt_q;
      assign valid_vec[s] = tag_q.valid;
   end

   always_comb begin
      rd_ok     = 1'b0;
      rd_kind   = 2'd0;
      rd_target = '0;
      for (int s = 0; s < NSLOT; s++) begin
         if (rd_slot == SLOT_W'(s + 1)) begin
            rd_ok     = tag_a[s].valid && !tag_a[s].bad;
            rd_kind   = tag_a[s].kind;
            rd_target = tgt_a[s];
         end
      end
   end

   p_fill_marks_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && w_slot_in |=> valid_vec != '0);

   p_slot0_keeps_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && w_slot == '0 |=> $stable(valid_vec));

endmodule

// File: rtl/xfer_cond_unit.sv
module xfer_cond_unit
   import xcu_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int NPRED  = 32,
   parameter int NSLOT  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pw_valid,
   input  logic [4:0]        pw_index,
   input  logic              pw_value,
   input  logic              loop_end,
   input  logic              prep_valid,
   input  logic [31:0]       prep_word,
   input  logic [ADDR_W-1:0] prep_pc,
   input  logic              req_valid,
   input  logic [8:0]        req_cond,
   input  logic [1:0]        req_slot,
   output logic              res_valid,
   output logic              res_taken,
   output logic [1:0]        res_kind,
   output logic [ADDR_W-1:0] res_target,
   output logic              res_illegal_cond,
   output logic              res_illegal_slot,
   output logic              prep_err
);

   localparam int TYPE_LSB = PIDX_W;

   if (CODE_W != PIDX_W + CTYPE_W) begin : g_bad_code
      $error("xfer_cond_unit: condition code fields do not add up");
   end

   logic pred_bit, hit, bad_code;
   logic ent_ok, wr_err;
   logic [1:0] ent_kind;
   logic [ADDR_W-1:0] ent_target;

   xcu_pred_file #(.NPRED(NPRED)) u_pf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (pw_valid),
      .wr_idx (pw_index),
      .wr_val (pw_value),
      .rd_idx (req_cond[PIDX_W-1:0]),
      .rd_val (pred_bit)
   );

   xcu_cond_eval u_ce (
      .ctype    (req_cond[TYPE_LSB +: CTYPE_W]),
      .pred     (pred_bit),
      .loop_end (loop_end),
      .hit      (hit),
      .bad_code (bad_code)
   );

   xcu_prep_bank #(.ADDR_W(ADDR_W), .NSLOT(NSLOT)) u_pb (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (prep_valid),
      .wr_word   (prep_word),
      .wr_pc     (prep_pc),
      .wr_err    (wr_err),
      .rd_slot   (req_slot),
      .rd_ok     (ent_ok),
      .rd_kind   (ent_kind),
      .rd_target (ent_target)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid        <= 1'b0;
         res_taken        <= 1'b0;
         res_kind         <= 2'd0;
         res_target       <= '0;
         res_illegal_cond <= 1'b0;
         res_illegal_slot <= 1'b0;
         prep_err         <= 1'b0;
      end else begin
         res_valid <= req_valid;
         prep_err  <= prep_valid && wr_err;
         if (req_valid) begin
            res_taken        <= hit && ent_ok && !bad_code;
            res_kind         <= ent_kind;
            res_target       <= ent_target;
            res_illegal_cond <= bad_code;
            res_illegal_slot <= !ent_ok;
         end else begin
            res_taken        <= 1'b0;
            res_illegal_cond <= 1'b0;
            res_illegal_slot <= 1'b0;
         end
      end
   end

   p_one_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);
   p_no_stray_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid);
   p_bad_code_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_illegal_cond |-> !res_taken);
   p_bad_slot_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_illegal_slot |-> !res_taken);
   p_never_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_cond[8:5] == 4'd0 |=> !res_taken);
   p_slot0_prep_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      prep_valid && prep_word[31:30] == 2'd0 |=> prep_err);

endmodule

// File: tb/tb_xfer_cond_unit.sv
module tb_xfer_cond_unit;

   localparam int AW = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pw_valid = 0, pw_value = 0, loop_end = 0, prep_valid = 0, req_valid = 0;
   logic [4:0] pw_index = 0;
   logic [31:0] prep_word = 0;
   logic [AW-1:0] prep_pc = 0;
   logic [8:0] req_cond = 0;
   logic [1:0] req_slot = 0;
   logic res_valid, res_taken, res_illegal_cond, res_illegal_slot, prep_err;
   logic [1:0] res_kind;
   logic [AW-1:0] res_target;

   int n_cmp = 0;
   int n_bad = 0;

   logic [31:0] pm = '0;
   logic m_ok [4];
   logic [1:0] m_kind [4];
   logic [AW-1:0] m_tgt [4];

   always #5 clk = ~clk;

   xfer_cond_unit #(.ADDR_W(AW), .NPRED(32), .NSLOT(3)) dut (
      .clk(clk), .rst_n(rst_n), .pw_valid(pw_valid), .pw_index(pw_index),
      .pw_value(pw_value), .loop_end(loop_end), .prep_valid(prep_valid),
      .prep_word(prep_word), .prep_pc(prep_pc), .req_valid(req_valid),
      .req_cond(req_cond), .req_slot(req_slot), .res_valid(res_valid),
      .res_taken(res_taken), .res_kind(res_kind), .res_target(res_target),
      .res_illegal_cond(res_illegal_cond), .res_illegal_slot(res_illegal_slot),
      .prep_err(prep_err));

   task automatic check(input bit ok, input string tag, input logic [AW-1:0] act,
                        input logic [AW-1:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      check(act === exp, tag, act, exp);
   endtask

   function automatic bit exp_hit(input int t, input bit p, input bit l);
      case (t)
         0: return 1'b0;
         1: return 1'b1;
         2: return p;
         3: return !p;
         4: return l;
         5: return !l;
         6: return p | l;
         7: return !p & !l;
         14: return !p | l;
         15: return p & !l;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [AW-1:0] exp_tgt(input int k, input logic [27:0] f,
                                             input logic [AW-1:0] pc);
      case (k)
         0, 1: return pc + ({36'd0, f} << 3);
         2: return {36'd0, f};
         default: return '0;
      endcase
   endfunction

   // model update for a prepare; returns expected error flag
   function automatic bit model_prep(input int s, input int k, input logic [27:0] f,
                                     input logic [AW-1:0] pc);
      bit bad;
      bad = (k == 1 && s != 2) || (k == 3 && f != 0);
      if (s != 0) begin
         m_ok[s] = !bad;
         m_kind[s] = 2'(k);
         m_tgt[s] = exp_tgt(k, f, pc);
      end
      return bad || s == 0;
   endfunction

   task automatic drive_prep(input int s, input int k, input logic [27:0] f,
                             input logic [AW-1:0] pc);
      prep_valid = 1'b1;
      prep_word = {2'(s), 2'(k), f};
      prep_pc = pc;
   endtask

   task automatic prep(input int s, input int k, input logic [27:0] f,
                       input logic [AW-1:0] pc, input string tag);
      bit e;
      @(negedge clk);
      drive_prep(s, k, f, pc);
      e = model_prep(s, k, f, pc);
      @(negedge clk);
      prep_valid = 1'b0;
      chk({tag, " prep_err"}, {63'd0, prep_err}, {63'd0, e});
   endtask

   task automatic wr_pred(input int i, input bit v);
      @(negedge clk);
      pw_valid = 1'b1; pw_index = 5'(i); pw_value = v;
      @(negedge clk);
      pw_valid = 1'b0;
      pm[i] = v;
   endtask

   task automatic req(input int t, input int idx, input int s, input bit l);
      @(negedge clk);
      req_valid = 1'b1; req_cond = {4'(t), 5'(idx)}; req_slot = 2'(s); loop_end = l;
      @(negedge clk);
      req_valid = 1'b0; loop_end = 1'b0;
   endtask

   // full result check against the slot model
   task automatic req_full(input int t, input int idx, input int s, input bit l,
                           input string tag);
      bit okslot, badc, tk;
      req(t, idx, s, l);
      okslot = (s != 0) && m_ok[s];
      badc = (t >= 8 && t <= 13);
      tk = exp_hit(t, pm[idx], l) && okslot && !badc;
      chk({tag, " res_valid"}, {63'd0, res_valid}, 64'd1);
      chk({tag, " taken"}, {63'd0, res_taken}, {63'd0, tk});
      chk({tag, " illegal_slot"}, {63'd0, res_illegal_slot}, {63'd0, !okslot});
      if (okslot) begin
         chk({tag, " kind"}, {62'd0, res_kind}, {62'd0, m_kind[s]});
         chk({tag, " target"}, res_target, m_tgt[s]);
      end
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int s = 0; s < 4; s++) begin
         m_ok[s] = 1'b0; m_kind[s] = 2'd0; m_tgt[s] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 res_valid", {63'd0, res_valid}, 64'd0);
      chk("R1 res_taken", {63'd0, res_taken}, 64'd0);
      chk("R1 prep_err", {63'd0, prep_err}, 64'd0);
      req_full(1, 0, 1, 0, "R1 unprepared slot");
      req_full(1, 0, 2, 0, "R1 unprepared slot2");

      // R7 documented example
      prep(1, 0, 28'h42, 64'h1000, "R7");
      req_full(1, 0, 1, 0, "R7 rel target");
      chk("R7 example", res_target, 64'h1210);

      // R1 predicates all zero after reset
      for (int i = 0; i < 32; i++) req_full(3, i, 1, 0, "R1 pred zero");

      // R2 writes, pattern
      for (int i = 0; i < 32; i++) wr_pred(i, ((i * 7 + 3) % 5) < 2);

      // R3 R4 R5 R12 sweep: every index, type and loop-end level
      for (int i = 0; i < 32; i++)
         for (int t = 0; t < 16; t++)
            for (int l = 0; l < 2; l++) begin
               string tg;
               tg = (t >= 8 && t <= 13) ? "R5" : (t >= 14 ? "R4" : "R3/R12");
               req(t, i, 1, l[0]);
               chk({tg, " taken"}, {63'd0, res_taken},
                   {63'd0, exp_hit(t, pm[i], l[0]) && !(t >= 8 && t <= 13)});
               chk({tg, " illegal_cond"}, {63'd0, res_illegal_cond},
                   {63'd0, (t >= 8 && t <= 13)});
            end

      // R12 loop end not held from an earlier cycle
      @(negedge clk); loop_end = 1'b1;
      @(negedge clk); loop_end = 1'b0;
      req_full(4, 0, 1, 0, "R12 stale loop_end");

      // R7 wrap, R8 syscall and return, R6 kinds
      prep(2, 1, 28'hFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF0, "R7 wrap");
      req_full(1, 0, 2, 0, "R7 prefetch wrap");
      prep(3, 2, 28'h000_001A, 64'h4000, "R8");
      req_full(1, 0, 3, 0, "R8 syscall");
      chk("R8 syscall number", res_target, 64'h1A);
      chk("R6 syscall kind", {62'd0, res_kind}, 64'd2);
      prep(1, 3, 28'h0, 64'h8000, "R8 ret");
      req_full(1, 0, 1, 0, "R8 return");
      chk("R6 return kind", {62'd0, res_kind}, 64'd3);

      // R10 slot 0 prepare: error, nothing changes
      prep(0, 0, 28'h77, 64'h9000, "R10 slot0");
      req_full(1, 0, 1, 0, "R10 slot1 intact");
      req_full(1, 0, 2, 0, "R10 slot2 intact");
      req_full(1, 0, 3, 0, "R10 slot3 intact");
      req_full(1, 0, 0, 0, "R9 slot0 request");

      // R9 ill-formed prepares
      prep(1, 3, 28'h5, 64'h100, "R9 ret offset");
      req_full(1, 0, 1, 0, "R9 ret offset request");
      prep(3, 1, 28'h10, 64'h100, "R9 pfl slot3");
      req_full(1, 0, 3, 0, "R9 pfl slot3 request");
      prep(1, 1, 28'h10, 64'h100, "R9 pfl slot1");
      req_full(1, 0, 1, 0, "R9 pfl slot1 request");

      // R11 same-cycle prepare and request on slot 2
      begin
         logic [AW-1:0] old_t;
         bit e;
         old_t = m_tgt[2];
         @(negedge clk);
         req_valid = 1'b1; req_cond = {4'd1, 5'd0}; req_slot = 2'd2;
         drive_prep(2, 0, 28'h123, 64'h2_0000);
         @(negedge clk);
         req_valid = 1'b0; prep_valid = 1'b0;
         chk("R11 old target", res_target, old_t);
         chk("R11 old kind", {62'd0, res_kind}, 64'd1);
         e = model_prep(2, 0, 28'h123, 64'h2_0000);
         chk("R11 prep_err", {63'd0, prep_err}, {63'd0, e});
         req_full(1, 0, 2, 0, "R11 new target");
      end

      // R2 same-cycle write and evaluation sees old predicate
      for (int i = 0; i < 32; i += 5) begin
         bit oldv;
         oldv = pm[i];
         @(negedge clk);
         pw_valid = 1'b1; pw_index = 5'(i); pw_value = !oldv;
         req_valid = 1'b1; req_cond = {4'd2, 5'(i)}; req_slot = 2'd2;
         @(negedge clk);
         pw_valid = 1'b0; req_valid = 1'b0;
         chk("R2 old value", {63'd0, res_taken}, {63'd0, oldv});
         pm[i] = !oldv;
         req_full(2, i, 2, 0, "R2 new value");
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule